// File: doc/BRIEF.md
# PLL Bring-Up Lock Qualifier

This controller brings a clock-synthesis PLL from cold to a qualified lock. When started, it takes a raw frequency-count word from the host side and checks that word for a validity signature. It turns the count into a host bus frequency and rounds that frequency to one of four bands. From the band it derives a low and a high reference window for a 66 MHz output target. It presents that window with tuning enabled and then watches the PLL's lock indication on a slow poll tick.

A lock is accepted only after it has been seen and has then stayed high for a long run of further samples. If the lock never appears within the poll budget, or drops during the stability run, the attempt fails. The window is then presented again with tuning off and the wait starts over, for a bounded number of attempts. The outcome is a one-cycle done pulse together with a success or fail flag. That flag stays valid until the next start. The analog PLL itself lies outside the block.

Top module: `pllBringup`

## Requirements
- R1: The count word is trusted only when bits 31:12 equal 0xABCDE. For any other word the band is 33 MHz, and bits 11:9 never affect the result.
- R2: For a trusted word, f = floor(count[8:0] * 77 / 192). The `band` output, a 7-bit binary MHz value, is 33 for f < 40, 40 for f < 45, 50 for f < 55, and 66 otherwise.
- R3: `winLow` = floor(band * 48 / 66) and `winHigh` = `winLow` + 2. `tuneEn` is 1 from the first window write until the first attempt ends.
- R4: Lock is sampled only on cycles with `tick` high. An attempt fails when POLL_LIMIT samples pass without lock. Lock seen on the last allowed sample still counts.
- R5: After lock is first seen, the next HOLD_COUNT samples must all be high. Done then rises on the last of those samples. A single low sample fails the attempt.
- R6: On a qualified lock, `tuneEn` drops to 0 while `winLow` and `winHigh` keep their values.
- R7: A failed attempt clears `tuneEn`, rewrites the window and starts a fresh poll. After MAX_TRIES failed attempts, `fail` is set. With lock never high, done therefore arrives on sample MAX_TRIES * POLL_LIMIT.
- R8: `fast66` is 1 exactly when the band exceeds 60 MHz.
- R9: `done` is a one-cycle pulse per accepted start. `success` and `fail` are never both 1, they hold until the next accepted start, and that start clears them.
- R10: A `start` pulse during a bring-up in progress is ignored. The band, the window and the completion time are unaffected.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up (accepted when idle) |
| countWord | input | 32 | Raw frequency-count word with signature |
| lock | input | 1 | PLL lock indication |
| tick | input | 1 | Poll strobe; lock is sampled when high |
| winLow | output | 8 | Low reference window bound |
| winHigh | output | 8 | High reference window bound |
| tuneEn | output | 1 | PLL tuning enable |
| band | output | 7 | Selected host bus band in MHz |
| fast66 | output | 1 | Host bus band above 60 MHz |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Lock qualified |
| fail | output | 1 | All attempts exhausted |

## Verification
A corrupted band register shows up at once as a window pair that does not match the count word, and as a wrong `fast66`. Both are visible from the cycle after measurement. A poll or hold counter that drifts by one moves the done pulse by exactly one tick, so the bench counts the ticks it issues and compares the tick on which done appears. A wrong attempt counter shows up in the same way, as an early or late fail, or as a retry missing entirely. A tuning enable that does not follow the attempt state is caught by sampling `tuneEn` on every cycle before done.

// File: rtl/pllBringupPkg.sv
package pllBringupPkg;
  localparam int BAND_W = 7;
  localparam int WIN_W = 8;
  localparam logic [19:0] SIGNATURE = 20'hABCDE;
  localparam int MUL_K = 77;
  localparam int DIV_K = 192;
  localparam int WIN_MUL = 48;
  localparam int WIN_DIV = 66;
  localparam int WIN_TOL = 2;

  typedef struct packed {
    logic loadCount;
    logic loadBand;
    logic writeWin;
    logic tuneOn;
    logic tuneOff;
  } dpStrobe_t;
endpackage

// File: rtl/pllBandPath.sv
module pllBandPath
  import pllBringupPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [31:0]       countWord,
  output logic [BAND_W-1:0] band,
  output logic [WIN_W-1:0]  winLow,
  output logic [WIN_W-1:0]  winHigh,
  output logic              tuneEn,
  output logic              fast66
);
  logic [31:0] cntReg;
  logic        sigOk;
  logic [16:0] prod;
  logic [16:0] freq;
  logic [BAND_W-1:0] bandNext;
  logic [12:0] winProd;
  logic [WIN_W-1:0] winCalc;

  assign sigOk = (cntReg[31:12] == SIGNATURE);
  assign prod  = 17'(cntReg[8:0]) * 17'(MUL_K);
  assign freq  = prod / 17'(DIV_K);

  always_comb begin
    if (!sigOk)              bandNext = BAND_W'(33);
    else if (freq < 17'd40)  bandNext = BAND_W'(33);
    else if (freq < 17'd45)  bandNext = BAND_W'(40);
    else if (freq < 17'd55)  bandNext = BAND_W'(50);
    else                     bandNext = BAND_W'(66);
  end

  assign winProd = 13'(band) * 13'(WIN_MUL);
  assign winCalc = WIN_W'(winProd / 13'(WIN_DIV));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg  <= '0;
      band    <= '0;
      winLow  <= '0;
      winHigh <= '0;
      tuneEn  <= 1'b0;
      fast66  <= 1'b0;
    end else begin
      if (stb.loadCount) cntReg <= countWord;
      if (stb.loadBand) begin
        band   <= bandNext;
        fast66 <= (bandNext > BAND_W'(60));
      end
      if (stb.writeWin) begin
        winLow  <= winCalc;
        winHigh <= winCalc + WIN_W'(WIN_TOL);
      end
      if (stb.tuneOn)       tuneEn <= 1'b1;
      else if (stb.tuneOff) tuneEn <= 1'b0;
    end
  end

  AST_WIN_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tuneEn) |-> (winHigh == winLow + WIN_W'(WIN_TOL))) else $error("window span"); // R3
endmodule

// File: rtl/pllLockCtrl.sv
module pllLockCtrl
  import pllBringupPkg::*;
#(
  parameter int POLL_LIMIT = 'h5000,
  parameter int HOLD_COUNT = 'h1000,
  parameter int MAX_TRIES  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      lock,
  input  logic      tick,
  output dpStrobe_t stb,
  output logic      done,
  output logic      success,
  output logic      fail
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);
  localparam int HOLD_W = $clog2(HOLD_COUNT + 1);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);

  typedef enum logic [2:0] {S_IDLE, S_MEAS, S_WIN, S_POLL, S_HOLD} state_t;
  state_t state;
  logic [POLL_W-1:0] pollCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic [TRY_W-1:0]  tryCnt;
  logic pollExpire, holdBreak, holdDone, attemptFail, lastTry;

  assign pollExpire  = (state == S_POLL) && tick && !lock && (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign holdBreak   = (state == S_HOLD) && tick && !lock;
  assign holdDone    = (state == S_HOLD) && tick && lock && (holdCnt == HOLD_W'(HOLD_COUNT - 1));
  assign attemptFail = pollExpire || holdBreak;
  assign lastTry     = (tryCnt == TRY_W'(MAX_TRIES - 1));

  always_comb begin
    stb = '0;
    stb.loadCount = (state == S_IDLE) && start;
    stb.loadBand  = (state == S_MEAS);
    stb.writeWin  = (state == S_WIN) || (attemptFail && !lastTry);
    stb.tuneOn    = (state == S_WIN);
    stb.tuneOff   = holdDone || attemptFail;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pollCnt <= '0;
      holdCnt <= '0;
      tryCnt  <= '0;
      done    <= 1'b0;
      success <= 1'b0;
      fail    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          success <= 1'b0;
          fail    <= 1'b0;
          state   <= S_MEAS;
        end
        S_MEAS: state <= S_WIN;
        S_WIN: begin
          tryCnt  <= '0;
          pollCnt <= '0;
          state   <= S_POLL;
        end
        S_POLL: if (tick) begin
          if (lock) begin
            holdCnt <= '0;
            state   <= S_HOLD;
          end else if (!pollExpire) begin
            pollCnt <= pollCnt + 1'b1;
          end
        end
        S_HOLD: if (tick && lock) begin
          if (holdDone) begin
            success <= 1'b1;
            done    <= 1'b1;
            state   <= S_IDLE;
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (attemptFail) begin
        if (lastTry) begin
          fail  <= 1'b1;
          done  <= 1'b1;
          state <= S_IDLE;
        end else begin
          tryCnt  <= tryCnt + 1'b1;
          pollCnt <= '0;
          state   <= S_POLL;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done width"); // R9
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(success && fail)) else $error("both results"); // R9
  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tryCnt < TRY_W'(MAX_TRIES)) else $error("attempt overrun"); // R7
endmodule

// File: rtl/pllBringup.sv
module pllBringup
  import pllBringupPkg::*;
#(
  parameter int POLL_LIMIT = 'h5000,
  parameter int HOLD_COUNT = 'h1000,
  parameter int MAX_TRIES  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] countWord,
  input  logic        lock,
  input  logic        tick,
  output logic [7:0]  winLow,
  output logic [7:0]  winHigh,
  output logic        tuneEn,
  output logic [6:0]  band,
  output logic        fast66,
  output logic        done,
  output logic        success,
  output logic        fail
);
  dpStrobe_t stb;

  pllLockCtrl #(.POLL_LIMIT(POLL_LIMIT), .HOLD_COUNT(HOLD_COUNT), .MAX_TRIES(MAX_TRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .lock(lock), .tick(tick),
    .stb(stb), .done(done), .success(success), .fail(fail));

  pllBandPath uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .countWord(countWord),
    .band(band), .winLow(winLow), .winHigh(winHigh), .tuneEn(tuneEn), .fast66(fast66));

  AST_TUNE_OFF_ON_SUCCESS: assert property (@(posedge clk) disable iff (!rstN)
    success |-> !tuneEn) else $error("tuning left on"); // R6
  AST_WIN_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (success && $past(success)) |-> ($stable(winLow) && $stable(winHigh))) else $error("window moved"); // R6
  AST_FAST_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (fast66 == (band > 7'd60))) else $error("fast flag"); // R8
endmodule

// File: tb/tb_pllBringup.sv
module tb_pllBringup;
  localparam int POLL = 12;
  localparam int HOLD = 6;
  localparam int TRIES = 3;
  localparam int NVEC = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] countWord = '0;
  logic lock = 1'b0;
  logic tick = 1'b0;
  logic [7:0] winLow, winHigh;
  logic tuneEn, fast66, done, success, fail;
  logic [6:0] band;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pllBringup #(.POLL_LIMIT(POLL), .HOLD_COUNT(HOLD), .MAX_TRIES(TRIES)) dut (
    .clk(clk), .rstN(rstN), .start(start), .countWord(countWord), .lock(lock), .tick(tick),
    .winLow(winLow), .winHigh(winHigh), .tuneEn(tuneEn), .band(band), .fast66(fast66),
    .done(done), .success(success), .fail(fail));

  // {count word, expected band, lock tick}
  localparam logic [46:0] VEC [NVEC] = '{
    {32'h12345064, 7'd33, 8'd1},
    {32'hABCDE063, 7'd33, 8'd5},
    {32'hABCDE064, 7'd40, 8'd12},
    {32'hABCDE070, 7'd40, 8'd2},
    {32'hABCDE071, 7'd50, 8'd7},
    {32'hABCDE089, 7'd50, 8'd3},
    {32'hABCDE08A, 7'd66, 8'd9},
    {32'hABCDE1FF, 7'd66, 8'd1},
    {32'hABCDEE64, 7'd40, 8'd6},
    {32'hABCDF064, 7'd33, 8'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One bring-up; lock is high on ticks >= lockAt except dropAt; lockAt=0 means never.
  task automatic run(input logic [31:0] cw, input int lockAt, input int dropAt, input int startAt,
                     output int doneTick, output bit sawOff);
    int tickNo = 0;
    int phase = 0;
    int guard = 0;
    doneTick = -1;
    sawOff = 1'b0;
    @(negedge clk);
    countWord = cw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!success && !fail, "R9 start clears result", int'({success, fail}), 0);
    repeat (4) @(negedge clk);
    while (doneTick < 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
      start = 1'b0;
      if (done) doneTick = tickNo;
      else if (!tuneEn) sawOff = 1'b1;
      tick = 1'b0;
      phase++;
      if (phase == 3 && doneTick < 0) begin
        phase = 0;
        tickNo++;
        tick = 1'b1;
        lock = (lockAt > 0) && (tickNo >= lockAt) && (tickNo != dropAt);
        if (tickNo == startAt) begin
          start = 1'b1;
          countWord = 32'h0;
        end
      end
    end
    tick = 1'b0;
    lock = 1'b0;
    @(negedge clk);
    chk(!done, "R9 done single cycle", int'(done), 0);
  endtask

  function automatic int winOf(input int b);
    return (b * 48) / 66;
  endfunction

  initial begin
    int dt;
    bit off;
    int eb;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(winLow == 0 && winHigh == 0 && !tuneEn && band == 0 && !fast66 && !done && !success && !fail,
        "R11 reset outputs", int'({winLow, winHigh, band}), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      eb = int'(VEC[i][14:8]);
      run(VEC[i][46:15], int'(VEC[i][7:0]), 0, 0, dt, off);
      chk(band == 7'(eb), "R1 R2 band", int'(band), eb);
      chk(winLow == 8'(winOf(eb)), "R3 window low", int'(winLow), winOf(eb));
      chk(winHigh == 8'(winOf(eb) + 2), "R3 window high", int'(winHigh), winOf(eb) + 2);
      chk(fast66 == (eb > 60), "R8 fast flag", int'(fast66), int'(eb > 60));
      chk(success && !fail, "R5 success flag", int'({success, fail}), 2);
      chk(dt == int'(VEC[i][7:0]) + HOLD, "R4 R5 done tick", dt, int'(VEC[i][7:0]) + HOLD);
      chk(!off, "R3 tuning held while polling", int'(off), 0);
      chk(!tuneEn, "R6 tuning off after lock", int'(tuneEn), 0);
    end

    // R4 boundary: lock one tick past the poll budget forces a retry
    run(32'hABCDE08A, POLL + 1, 0, 0, dt, off);
    chk(dt == POLL + 1 + HOLD, "R4 late lock retried", dt, POLL + 1 + HOLD);
    chk(off && success, "R7 retry with tuning off", int'({off, success}), 3);

    // R5 drop on last hold sample
    run(32'hABCDE071, 3, 3 + HOLD, 0, dt, off);
    chk(dt == 3 + HOLD + 1 + HOLD, "R5 hold drop restarts", dt, 3 + HOLD + 1 + HOLD);
    chk(success, "R5 success after drop", int'(success), 1);

    // R7 never locks
    run(32'hABCDE1FF, 0, 0, 0, dt, off);
    chk(dt == TRIES * POLL, "R7 fail timing", dt, TRIES * POLL);
    chk(fail && !success, "R7 fail flag", int'({success, fail}), 1);
    chk(!tuneEn && winLow == 8'(winOf(66)) && winHigh == 8'(winOf(66) + 2), "R6 R7 window kept on fail",
        int'(winLow), winOf(66));
    repeat (5) @(negedge clk);
    chk(fail && !success, "R9 fail held", int'({success, fail}), 1);

    // R10 start during bring-up ignored
    run(32'hABCDE071, 4, 0, 2, dt, off);
    chk(band == 7'd50, "R10 band unchanged", int'(band), 50);
    chk(dt == 4 + HOLD, "R10 timing unchanged", dt, 4 + HOLD);
    chk(winLow == 8'(winOf(50)), "R10 window unchanged", int'(winLow), winOf(50));

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule